// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block produces one output clock from its parent clock. In bypass mode the parent clock passes straight through. In divide mode the output is built from two phase counts that are programmed separately. The output holds high for one programmed number of parent cycles and then low for another, so both the period and the duty cycle can be chosen. A gate after the divider either lets the clock through or holds it low. The gate changes state only while the clock is low, so switching it on or off never produces a short pulse.

Software programs the block through a small valid/ready register port. The configuration word holds a divide-enable bit, a high-phase count and a low-phase count. The gate word holds one enable bit. The counter copies new configuration values only at the end of a complete output period. A parameter can remove the gate from an instance; that instance's output is then always running.

Top module: `duty_clk_div`

## Requirements
- R1: After the active-low reset is released, both registers read back as zero and the output stays low, because the divider is in bypass and the gate is closed. The register port shows ready high and no response pending.
- R2: While the divide-enable bit (configuration bit 0) is clear and the gate is open, the output follows the parent clock. This holds whatever values the high and low count fields contain.
- R3: While divide-enable is set, each high phase of the output lasts (high field + 1) parent cycles. The high field is configuration bits [11:8].
- R4: While divide-enable is set, each low phase of the output lasts (low field + 1) parent cycles. The low field is configuration bits [19:16].
- R5: The divided period is (high field + 1) + (low field + 1) parent cycles. With both fields at zero, the output divides by two with a 50% duty cycle.
- R6: A configuration write that arrives partway through an output period takes effect only when that period ends. The period in progress completes with its old high and low lengths.
- R7: Gate bit 0 of the gate word (address 0x4) passes the clock when set. When it is clear, the output is held low in both bypass and divide modes.
- R8: Closing the gate during a high phase does not shorten that phase. The gate opens or closes only while the output is low.
- R9: With the gate removed by parameter, the output runs from reset onward. Writes to the gate bit change nothing, and the gate word always reads back as 1.
- R10: An accepted read returns its data with the response valid exactly one cycle later. Ready is low while that response is shown. The configuration word (address 0x0) reads back only bits 0, [11:8] and [19:16]. Any address other than 0x0 or 0x4 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: 0x0 configuration, 0x4 gate |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| clk_out | output | 1 | Divided, bypassed and gated output clock |

## Verification
Shadowed phase lengths that are wrong would show on the very next output pulse as a high or low run of the wrong length. The bench therefore counts every run in parent cycles, including the two runs on either side of a reprogram made mid-period. A gate state that is wrong, or one that changes at the wrong moment, would show within one period: either as a high phase cut short after the gate is cleared, or as an output that does not stay low while the gate is closed. A register decode that is wrong would show in the read data one cycle after the read is accepted, and in how the divider then behaves.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned EN_POS   = 0;
    localparam int unsigned HI_POS   = 8;
    localparam int unsigned LO_POS   = 16;
    localparam int unsigned GATE_POS = 0;
    localparam int unsigned CFG_OFS  = 0;
    localparam int unsigned GATE_OFS = 4;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;
endpackage

// File: rtl/cdiv_regs.sv
`timescale 1ns/1ps
module cdiv_regs
    import cdiv_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned ADDR_W   = 4,
    parameter bit          HAS_GATE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [REG_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic [REG_W-1:0]   rsp_rdata,
    output logic               cfg_en,
    output logic [CNT_W-1:0]   cfg_hi,
    output logic [CNT_W-1:0]   cfg_lo,
    output logic               gate_req
);
    localparam logic [REG_W-1:0]  FIELD_ONES = REG_W'((64'd1 << CNT_W) - 64'd1);
    localparam logic [REG_W-1:0]  CFG_MASK   = (REG_W'(1) << EN_POS)
                                             | (FIELD_ONES << HI_POS)
                                             | (FIELD_ONES << LO_POS);
    localparam logic [ADDR_W-1:0] A_CFG      = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] A_GATE     = ADDR_W'(GATE_OFS);
    localparam logic              GATE_RST   = !HAS_GATE;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic             gate;
        logic             rsp_v;
        logic [REG_W-1:0] rsp_d;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic  accept;

    always_comb begin
        nxt_d       = cur_q;
        accept      = req_valid && !cur_q.rsp_v;
        nxt_d.rsp_v = accept && !req_write;
        if (accept && req_write) begin
            if (req_addr == A_CFG) begin
                nxt_d.cfg = req_wdata & CFG_MASK;
            end
            if (HAS_GATE && (req_addr == A_GATE)) begin
                nxt_d.gate = req_wdata[GATE_POS];
            end
        end
        if (accept && !req_write) begin
            if (req_addr == A_CFG) begin
                nxt_d.rsp_d = cur_q.cfg;
            end else if (req_addr == A_GATE) begin
                nxt_d.rsp_d = REG_W'(cur_q.gate) << GATE_POS;
            end else begin
                nxt_d.rsp_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.gate <= GATE_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = !cur_q.rsp_v;
    assign rsp_valid = cur_q.rsp_v;
    assign rsp_rdata = cur_q.rsp_d;
    assign cfg_en    = cur_q.cfg[EN_POS];
    assign cfg_hi    = cur_q.cfg[HI_POS +: CNT_W];
    assign cfg_lo    = cur_q.cfg[LO_POS +: CNT_W];
    assign gate_req  = cur_q.gate;

    // R10: a response only follows a read accepted on the previous edge
    p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write))
        else $error("p_rsp_after_read_r10");
endmodule

// File: rtl/cdiv_phase.sv
`timescale 1ns/1ps
module cdiv_phase
    import cdiv_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [CNT_W-1:0] cfg_hi,
    input  logic [CNT_W-1:0] cfg_lo,
    output logic             div_en,
    output logic             div_lvl,
    output logic             quiet_next
);
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } phase_t;

    phase_t st_q, st_d;
    logic   period_end;

    always_comb begin
        st_d       = st_q;
        period_end = !st_q.en || ((st_q.cnt == '0) && (st_q.ph == PH_LOW));
        if (period_end) begin
            st_d.en  = cfg_en;
            st_d.hi  = cfg_hi;
            st_d.lo  = cfg_lo;
            st_d.ph  = cfg_en ? PH_HIGH : PH_LOW;
            st_d.cnt = cfg_en ? cfg_hi : '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.ph  = PH_LOW;
            st_d.cnt = st_q.lo;
        end
        quiet_next = !(st_d.en && (st_d.ph == PH_HIGH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_en  = st_q.en;
    assign div_lvl = (st_q.ph == PH_HIGH);

    // R3: remaining high count never exceeds the captured high length
    p_high_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.ph == PH_HIGH) |-> (st_q.cnt <= st_q.hi))
        else $error("p_high_bound_r3");

    // R4: remaining low count never exceeds the captured low length
    p_low_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.ph == PH_LOW) |-> (st_q.cnt <= st_q.lo))
        else $error("p_low_bound_r4");

    // R5: high-to-low turn happens only after the high count ran out
    p_turn_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.en) && st_q.en && $past(st_q.ph == PH_HIGH) && (st_q.ph == PH_LOW))
            |-> ($past(st_q.cnt) == '0))
        else $error("p_turn_at_zero_r5");

    // R6: captured lengths stay put unless the previous cycle closed a period
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_end) |-> ($stable(st_q.hi) && $stable(st_q.lo) && $stable(st_q.en)))
        else $error("p_shadow_hold_r6");
endmodule

// File: rtl/cdiv_gate.sv
`timescale 1ns/1ps
module cdiv_gate #(
    parameter bit RST_ON = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    input  logic quiet_next,
    output logic gate_on
);
    logic live_q, live_d;
    logic on_q;

    always_comb begin
        live_d = quiet_next ? gate_req : live_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= RST_ON;
        end else begin
            live_q <= live_d;
        end
    end

    // retimed on the falling edge so a bypassed clock is gated while low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q <= RST_ON;
        end else begin
            on_q <= live_q;
        end
    end

    assign gate_on = on_q;
endmodule

// File: rtl/duty_clk_div.sv
`timescale 1ns/1ps
module duty_clk_div
    import cdiv_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned ADDR_W   = 4,
    parameter bit          HAS_GATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              clk_out
);
    logic             cfg_en;
    logic [CNT_W-1:0] cfg_hi;
    logic [CNT_W-1:0] cfg_lo;
    logic             gate_req;
    logic             div_en;
    logic             div_lvl;
    logic             quiet_next;
    logic             gate_on;

    cdiv_regs #(
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .HAS_GATE (HAS_GATE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .cfg_en    (cfg_en),
        .cfg_hi    (cfg_hi),
        .cfg_lo    (cfg_lo),
        .gate_req  (gate_req)
    );

    cdiv_phase #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_hi     (cfg_hi),
        .cfg_lo     (cfg_lo),
        .div_en     (div_en),
        .div_lvl    (div_lvl),
        .quiet_next (quiet_next)
    );

    cdiv_gate #(
        .RST_ON (!HAS_GATE)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_req   (gate_req),
        .quiet_next (quiet_next),
        .gate_on    (gate_on)
    );

    assign clk_out = (div_en ? div_lvl : clk) & gate_on;

    // R8: in divide mode the gate never moves across a cycle where the output is high
    p_gate_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && div_lvl) |-> $stable(gate_on))
        else $error("p_gate_steady_r8");
endmodule

// File: tb/duty_clk_div_test.sv
`timescale 1ns/1ps
module duty_clk_div_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, clk_out;
    logic [31:0] rsp_rdata;
    logic        ng_ready, ng_rsp_valid, ng_clk_out;
    logic [31:0] ng_rdata;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    duty_clk_div uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .clk_out(clk_out)
    );

    duty_clk_div #(.HAS_GATE(1'b0)) uut_ng (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ng_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(ng_rsp_valid), .rsp_rdata(ng_rdata), .clk_out(ng_clk_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #2;
        req_valid = 1'b0; req_write = 1'b0;
        idle(1);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d,
                            output logic [31:0] nd, output logic v, output logic rdy);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #2;
        d = rsp_rdata; nd = ng_rdata; v = rsp_valid; rdy = req_ready;
        req_valid = 1'b0;
        idle(1);
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 1'b0;
        @(posedge clk); #2;
        prev = clk_out;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #2;
            if (!prev && clk_out) begin ok = 1'b1; break; end
            prev = clk_out;
        end
    endtask

    task automatic run_len(input logic lvl, input int start, output int n);
        n = start;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #2;
            if (clk_out !== lvl) break;
            n++;
        end
    endtask

    task automatic measure(output int h, output int l);
        bit ok;
        wait_rise(ok);
        run_len(1'b1, 1, h);
        run_len(1'b0, 1, l);
        if (!ok) begin h = -1; l = -1; end
    endtask

    function automatic logic [31:0] cfg_word(input bit en, input int hi, input int lo);
        return (32'(en)) | (32'(hi) << 8) | (32'(lo) << 16);
    endfunction

    // count half-cycle samples that disagree with the parent clock
    task automatic bypass_errs(input int cycles, output int errs);
        errs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #2;
            if (clk_out !== 1'b1) errs++;
            #5;
            if (clk_out !== 1'b0) errs++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d, nd; logic v, rdy; int highs, ng_highs;
        highs = 0; ng_highs = 0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            highs += int'(clk_out); ng_highs += int'(ng_clk_out);
            #5;
            highs += int'(clk_out);
        end
        chk("R1 output low after reset", highs, 0);
        chk("R9 ungated instance runs from reset", ng_highs, 4);
        chk("R1 ready high", req_ready, 1);
        chk("R1 no response pending", rsp_valid, 0);
        bus_read(4'h0, d, nd, v, rdy);
        chk("R1 config reads zero", d, 0);
        bus_read(4'h4, d, nd, v, rdy);
        chk("R1 gate reads zero", d, 0);
        chk("R9 ungated gate reads one", nd, 1);
    endtask

    task automatic t_bypass;
        int errs;
        bus_write(4'h4, 32'h1);
        bus_write(4'h0, cfg_word(1'b0, 7, 3));
        idle(3);
        bypass_errs(6, errs);
        chk("R2 bypass follows parent, fields ignored", errs, 0);
    endtask

    task automatic t_divide(input int hi, input int lo);
        int h, l;
        bus_write(4'h0, cfg_word(1'b1, hi, lo));
        measure(h, l);
        chk($sformatf("R3 high run hi=%0d lo=%0d", hi, lo), h, hi + 1);
        chk($sformatf("R4 low run hi=%0d lo=%0d", hi, lo), l, lo + 1);
        chk($sformatf("R5 period hi=%0d lo=%0d", hi, lo), h + l, hi + lo + 2);
    endtask

    task automatic t_reprogram;
        int h1, l1, h2, l2, h, l; bit ok;
        bus_write(4'h0, cfg_word(1'b1, 3, 3));
        measure(h, l);
        wait_rise(ok);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h0; req_wdata = cfg_word(1'b1, 1, 0);
        @(posedge clk); #2;
        req_valid = 1'b0; req_write = 1'b0;
        run_len(1'b1, 2, h1);
        run_len(1'b0, 1, l1);
        run_len(1'b1, 1, h2);
        run_len(1'b0, 1, l2);
        chk("R6 period in flight keeps old high", h1, 4);
        chk("R6 period in flight keeps old low", l1, 4);
        chk("R6 next period new high", h2, 2);
        chk("R6 next period new low", l2, 1);
    endtask

    task automatic t_gate;
        int h, l, highs, ng_rises, errs; bit ok; logic prev;
        bus_write(4'h0, cfg_word(1'b1, 5, 5));
        measure(h, l);
        wait_rise(ok);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h4; req_wdata = 32'h0;
        @(posedge clk); #2;
        req_valid = 1'b0; req_write = 1'b0;
        run_len(1'b1, 2, h);
        chk("R8 high phase not cut by gate close", h, 6);
        highs = 0; ng_rises = 0; prev = ng_clk_out;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #2;
            highs += int'(clk_out);
            if (!prev && ng_clk_out) ng_rises++;
            prev = ng_clk_out;
            #5;
            highs += int'(clk_out);
        end
        chk("R7 closed gate holds output low", highs, 0);
        chk("R9 gate write ignored when gate removed", int'(ng_rises >= 3), 1);
        bus_write(4'h4, 32'h1);
        measure(h, l);
        chk("R8 first pulse after open is whole", h, 6);
        chk("R7 open gate passes divided clock", l, 6);
        bus_write(4'h0, 32'h0);
        idle(14);
        bus_write(4'h4, 32'h0);
        idle(2);
        highs = 0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #2; highs += int'(clk_out); #5; highs += int'(clk_out);
        end
        chk("R7 closed gate holds bypass low", highs, 0);
        bus_write(4'h4, 32'h1);
        idle(2);
        bypass_errs(4, errs);
        chk("R7 reopened gate passes bypass", errs, 0);
    endtask

    task automatic t_readback;
        logic [31:0] d, nd; logic v, rdy;
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, d, nd, v, rdy);
        chk("R10 config read masked", d, 32'h000F_0F01);
        chk("R10 response valid one cycle after accept", v, 1);
        chk("R10 ready low while response shown", rdy, 0);
        chk("R10 response lasts one cycle", rsp_valid, 0);
        bus_read(4'h8, d, nd, v, rdy);
        chk("R10 unknown address reads zero", d, 0);
        bus_write(4'h4, 32'h0);
        bus_read(4'h4, d, nd, v, rdy);
        chk("R10 gate reads back written value", d, 0);
        chk("R9 removed gate still reads one", nd, 1);
        bus_write(4'h0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_divide(0, 0);
        t_divide(2, 5);
        t_divide(15, 1);
        t_divide(3, 3);
        t_reprogram();
        t_gate();
        t_readback();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule